// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block watches 23 asynchronous input lines and turns selected transitions on them into latched interrupt requests. Each line can be set to react to its rising transition, its falling transition or both. A detected transition, or a software trigger, sets a per-line pending flag. The flag stays set until software writes 1 to it. Pending flags that are unmasked drive level interrupt outputs. Some lines each have their own output, and two groups of lines are merged onto shared outputs.

A second, independent path gives one-cycle event pulses. A line produces a pulse when its event enable is set. This path works whatever the state of the interrupt mask.

Software reaches the block through a plain 32-bit register port. A write strobe, a 3-bit word index and write data apply on a rising clock edge. Read data is combinational from the word index. The port carries single register accesses and has no streaming data, so it has no valid/ready handshake and never applies back-pressure. Each write is accepted in the cycle it is presented.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Line n is held in bit n of every register, for n from 0 to 22. Bits [31:23] of every register read as zero. The word indices are: 0 interrupt mask, 1 event enable, 2 rising select, 3 falling select, 4 software trigger, 5 pending. Indices 6 and 7 read as zero.
- R2: After reset, every register reads zero, every interrupt output is low and every event output is low. All interrupts are therefore masked.
- R3: Each input passes through a two-stage synchronizer. A rising transition on a line with its rising select bit set sets that line's pending bit, and so does a falling transition on a line with its falling select bit set. A line may select both. A transition whose select bit is clear has no effect. The pending bit reads 1 from the third rising clock edge after the input changes.
- R4: A pending bit is cleared only by a register write of 1 to that bit at index 5. Writing 0 leaves the bit unchanged.
- R5: An interrupt output is high exactly while at least one pending bit mapped to it is set and has its interrupt mask bit at 1. The mask does not stop the pending bit from being set. Unmasking an already pending line raises its output.
- R6: If a selected transition and a write-1 clear reach the same pending bit in the same cycle, the bit stays set.
- R7: Writing 1 to a software trigger bit sets that bit and the matching pending bit on the same clock edge. The trigger bit reads 1 until the pending bit is cleared, and clearing the pending bit also clears the trigger bit.
- R8: When a line's event enable bit is 1, a selected transition or a software trigger on that line drives evt_out[n] high for exactly one cycle. The pulse rises on the same clock edge as the pending bit. With the event enable bit at 0, no pulse is produced.
- R9: Interrupt output mapping: lines 0 to 4 drive irq_out[0] to irq_out[4]. Lines 5 to 9 are ORed onto irq_out[5]. Lines 10 to 15 are ORed onto irq_out[6]. Lines 16 to 22 drive irq_out[7] to irq_out[13]. A shared output stays high until the last contributing pending bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 23 | Asynchronous external lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 14 | Level interrupt outputs |
| evt_out | output | 23 | One-cycle event pulses per line |

## Verification
If a pending flag is lost or stuck, it shows at the ports in two places. Readback at index 5 reflects it at once, and the mapped interrupt output reflects it in the same cycle. A wrong synchronizer depth moves the set edge away from the third clock. A wrong merge in the output mapping shows a shared output that falls too early or rises for the wrong line.

The dangerous corners are single-cycle coincidences: a clear that meets a fresh transition, and a software trigger that must survive until its pending bit is cleared. The checks pin these to exact edges and sample the results one half-period later.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned SOLO_LO = 5;  // lines with their own output below this
  localparam int unsigned GRP_A_N = 5;  // first merged group size
  localparam int unsigned GRP_B_N = 6;  // second merged group size

  typedef enum logic [ADDR_W-1:0] {
    RI_IMASK  = 3'd0,
    RI_EMASK  = 3'd1,
    RI_RISE   = 3'd2,
    RI_FALL   = 3'd3,
    RI_SWTRIG = 3'd4,
    RI_PEND   = 3'd5
  } reg_idx_e;

  // output index served by a given line
  function automatic int unsigned out_of_line(input int unsigned ln);
    if (ln < SOLO_LO) return ln;
    if (ln < SOLO_LO + GRP_A_N) return SOLO_LO;
    if (ln < SOLO_LO + GRP_A_N + GRP_B_N) return SOLO_LO + 1;
    return ln - (GRP_A_N + GRP_B_N) + 2;
  endfunction

  function automatic int unsigned out_count(input int unsigned n_lines);
    return out_of_line(n_lines - 1) + 1;
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned N = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic meta_q, sync_q, hist_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        hist_q <= 1'b0;
      end else begin
        meta_q <= din[g];
        sync_q <= meta_q;
        hist_q <= sync_q;
      end
    end
    assign rise_o[g] = sync_q & ~hist_q;
    assign fall_o[g] = ~sync_q & hist_q;
  end
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned N  = 23,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [N-1:0]      rise_ev,
  input  logic [N-1:0]      fall_ev,
  output logic [N-1:0]      imask_o,
  output logic [N-1:0]      pend_o,
  output logic [N-1:0]      evt_o
);
  localparam int unsigned PAD = DW - N;

  logic [N-1:0] imask_q, emask_q, rise_q, fall_q, sw_q, pend_q, evt_q;
  logic [N-1:0] hw_trig, sw_set, clr, trig;
  logic [N-1:0] wd;
  logic         wdata_unused;

  assign wd           = wdata[N-1:0];
  assign wdata_unused = ^wdata[DW-1:N];

  assign hw_trig = (rise_ev & rise_q) | (fall_ev & fall_q);
  assign sw_set  = (we && addr == RI_SWTRIG) ? wd : '0;
  assign clr     = (we && addr == RI_PEND)   ? wd : '0;
  assign trig    = hw_trig | sw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else if (we) begin
      case (addr)
        RI_IMASK: imask_q <= wd;
        RI_EMASK: emask_q <= wd;
        RI_RISE:  rise_q  <= wd;
        RI_FALL:  fall_q  <= wd;
        default:  ;
      endcase
    end
  end

  // set has priority over write-1 clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      sw_q   <= '0;
      evt_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | trig;
      sw_q   <= (sw_q & ~clr) | sw_set;
      evt_q  <= trig & emask_q;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RI_IMASK:  rdata = {{PAD{1'b0}}, imask_q};
      RI_EMASK:  rdata = {{PAD{1'b0}}, emask_q};
      RI_RISE:   rdata = {{PAD{1'b0}}, rise_q};
      RI_FALL:   rdata = {{PAD{1'b0}}, fall_q};
      RI_SWTRIG: rdata = {{PAD{1'b0}}, sw_q};
      RI_PEND:   rdata = {{PAD{1'b0}}, pend_q};
      default:   rdata = '0;
    endcase
  end

  assign imask_o = imask_q;
  assign pend_o  = pend_q;
  assign evt_o   = evt_q;

  // R3: a selected transition leaves its pending bit set on the next edge
  p_sel_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_trig != '0) |=> ((pend_q & $past(hw_trig)) == $past(hw_trig)));

  // R4: bits not written with 1 are never cleared
  p_w0_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr)) & ~pend_q) == '0));

  // R6: coincident transition and clear leave the bit set
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_trig & clr) != '0) |=> ((pend_q & $past(hw_trig & clr)) == $past(hw_trig & clr)));

  // R7: a trigger bit never outlives its pending bit
  p_sw_implies_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_q & ~pend_q) == '0));

  // R8: an event pulse needs the event enable of the previous cycle
  p_evt_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(emask_q)) == '0));
endmodule

// File: rtl/edge_irq_route.sv
module edge_irq_route
  import edge_irq_pkg::*;
#(
  parameter int unsigned N = 23,
  parameter int unsigned M = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] imask,
  output logic [M-1:0] irq
);
  logic [N-1:0] live;
  assign live = pend & imask;

  always_comb begin
    irq = '0;
    for (int i = 0; i < N; i++) begin
      irq[out_of_line(i)] = irq[out_of_line(i)] | live[i];
    end
  end

  // R5: no unmasked pending line means every output is low
  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> (irq == '0));

  // R9: the number of active outputs never exceeds the number of live lines
  p_irq_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq) <= $countones(live)));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 23,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned NUM_OUT  = out_count(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_in,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_OUT-1:0]   irq_out,
  output logic [NUM_LINES-1:0] evt_out
);
  logic [NUM_LINES-1:0] rise_ev, fall_ev, imask, pend;

  edge_sync #(.N(NUM_LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (ext_in),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  edge_irq_regs #(.N(NUM_LINES), .DW(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .imask_o (imask),
    .pend_o  (pend),
    .evt_o   (evt_out)
  );

  edge_irq_route #(.N(NUM_LINES), .M(NUM_OUT)) u_route (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .imask (imask),
    .irq   (irq_out)
  );

  // R1: reserved read bits stay zero
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DATA_W-1:NUM_LINES] == '0));
endmodule

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] ext_in = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [13:0] irq_out;
  logic [22:0] evt_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .evt_out(evt_out)
  );

  localparam logic [2:0] A_IM = 3'd0, A_EM = 3'd1, A_RS = 3'd2,
                         A_FL = 3'd3, A_SW = 3'd4, A_PD = 3'd5;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cleanup();
    wr(A_PD, 32'h007F_FFFF);
    wr(A_IM, 0); wr(A_EM, 0); wr(A_RS, 0); wr(A_FL, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R2 register reset value", d, 0);
    end
    chk("R2 irq_out after reset", {18'b0, irq_out}, 0);
    chk("R2 evt_out after reset", {9'b0, evt_out}, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(A_IM, 32'hFFFF_FFFF);
    rd(A_IM, d);
    chk("R1 reserved bits read zero", d, 32'h007F_FFFF);
    rd(3'd6, d);
    chk("R1 index 6 reads zero", d, 0);
    wr(A_IM, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(A_RS, 1 << 3); wr(A_IM, 1 << 3);
    ext_in[3] = 1'b1;
    tick(2);
    rd(A_PD, d);
    chk("R3 pending not yet set at second edge", d, 0);
    tick(1);
    rd(A_PD, d);
    chk("R3 rising sets pending at third edge", d, 1 << 3);
    chk("R9 line 3 drives irq_out[3]", {18'b0, irq_out}, 1 << 3);
    wr(A_PD, 1 << 3);
    chk("R5 clear drops irq_out", {18'b0, irq_out}, 0);
    ext_in[3] = 1'b0;
    tick(4);
    rd(A_PD, d);
    chk("R3 unselected falling ignored", d, 0);
    cleanup();
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(A_RS, 1 << 17); wr(A_FL, 1 << 17); wr(A_IM, 1 << 17);
    ext_in[17] = 1'b1;
    tick(3);
    rd(A_PD, d);
    chk("R3 both-edge line rising", d, 1 << 17);
    chk("R9 line 17 drives irq_out[8]", {18'b0, irq_out}, 1 << 8);
    wr(A_PD, 32'h007F_FFFF & ~(32'd1 << 17));
    rd(A_PD, d);
    chk("R4 writing 0 keeps pending", d, 1 << 17);
    wr(A_PD, 1 << 17);
    ext_in[17] = 1'b0;
    tick(3);
    rd(A_PD, d);
    chk("R3 both-edge line falling", d, 1 << 17);
    cleanup();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_RS, 1);
    ext_in[0] = 1'b1;
    tick(3);
    rd(A_PD, d);
    chk("R5 pending set while masked", d, 1);
    chk("R5 masked line keeps irq low", {18'b0, irq_out}, 0);
    wr(A_IM, 1);
    chk("R5 unmask raises irq_out[0]", {18'b0, irq_out}, 1);
    ext_in[0] = 1'b0;
    cleanup();
  endtask

  task automatic t_shared();
    wr(A_RS, (1 << 6) | (1 << 8));
    wr(A_IM, (1 << 6) | (1 << 8) | (1 << 12));
    ext_in[6] = 1'b1;
    tick(3);
    chk("R9 line 6 on irq_out[5]", {18'b0, irq_out}, 1 << 5);
    ext_in[8] = 1'b1;
    tick(3);
    wr(A_PD, 1 << 6);
    chk("R9 shared output held by line 8", {18'b0, irq_out}, 1 << 5);
    wr(A_PD, 1 << 8);
    chk("R9 shared output drops after last clear", {18'b0, irq_out}, 0);
    wr(A_SW, 1 << 12);
    chk("R9 line 12 on irq_out[6]", {18'b0, irq_out}, 1 << 6);
    ext_in[6] = 1'b0; ext_in[8] = 1'b0;
    cleanup();
  endtask

  task automatic t_sw();
    logic [31:0] d;
    wr(A_IM, 1 << 20);
    wr(A_SW, 1 << 20);
    rd(A_SW, d);
    chk("R7 trigger bit reads 1", d, 1 << 20);
    rd(A_PD, d);
    chk("R7 trigger sets pending", d, 1 << 20);
    chk("R7 trigger raises irq_out[11]", {18'b0, irq_out}, 1 << 11);
    tick(3);
    rd(A_SW, d);
    chk("R7 trigger bit held", d, 1 << 20);
    wr(A_PD, 1 << 20);
    rd(A_SW, d);
    chk("R7 clear also clears trigger bit", d, 0);
    cleanup();
  endtask

  task automatic t_evt();
    logic [31:0] d;
    wr(A_RS, (1 << 4) | (1 << 5)); wr(A_EM, 1 << 4);
    ext_in[4] = 1'b1;
    tick(3);
    chk("R8 event pulse on enabled line", {9'b0, evt_out}, 1 << 4);
    tick(1);
    chk("R8 event pulse lasts one cycle", {9'b0, evt_out}, 0);
    ext_in[5] = 1'b1;
    tick(3);
    chk("R8 no pulse without event enable", {9'b0, evt_out}, 0);
    rd(A_PD, d);
    chk("R8 pending set on both lines", d, (1 << 4) | (1 << 5));
    wr(A_SW, 1 << 4);
    chk("R8 software trigger pulses event", {9'b0, evt_out}, 1 << 4);
    tick(1);
    chk("R8 software pulse ends", {9'b0, evt_out}, 0);
    ext_in[4] = 1'b0; ext_in[5] = 1'b0;
    cleanup();
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    wr(A_RS, 1 << 2);
    ext_in[2] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(A_PD, 1 << 2);
    rd(A_PD, d);
    chk("R6 set wins over clear", d, 1 << 2);
    wr(A_PD, 1 << 2);
    rd(A_PD, d);
    chk("R4 later clear succeeds", d, 0);
    ext_in[2] = 1'b0;
    cleanup();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_reserved();
    t_rise();
    t_both();
    t_mask();
    t_shared();
    t_sw();
    t_evt();
    t_setwins();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule